// File: doc/BRIEF.md
# Programmable Delay-Timer Tick Divider

This block turns a reference event stream into an evenly spaced enable pulse for the timer that spaces conversions apart. Two references arrive as single-cycle edge strobes in the system clock domain: one from the on-chip oscillator and one from the external master clock. An 8-bit control register picks which reference is counted and how many of its edges make up one tick period. The aim is a tick near 1 MHz. The tick paces the delay only and never clocks any conversion logic.

Bit 7 of the register selects the reference: 0 selects the internal oscillator and 1 selects the external master clock. Bits 6..0 hold the divide ratio. A value N from 1 to 127 divides by N, and 0 divides by 128. A new ratio is loaded only when the running period ends. A change of source restarts the count from zero.

The counter is driven by a two-state machine. RESTART clears the count, loads the ratio and adopts the selected source. COUNT counts edges and emits ticks. The transitions are: reset→RESTART; RESTART→COUNT (always, after one cycle); COUNT→COUNT (source bit unchanged); COUNT→RESTART (source bit differs from the adopted source).

Top module: `tick_divider`

## Requirements
- R1: During and after reset, `rd_data` reads 8'h80 (external source, divide by 128), and `tick` is low. The first cycle after reset is a RESTART cycle in which edges are not counted.
- R2: A write with `wr_en` high stores `wr_data`, and `rd_data` shows it from the next cycle on. Without a write, `rd_data` holds its value.
- R3: With bit 7 = 0 only `int_edge` is counted, and with bit 7 = 1 only `ext_edge` is counted. The other strobe has no effect on `tick`.
- R4: With bits 6..0 = N (1..127), `tick` rises for exactly one cycle, in the cycle after every N-th counted edge. This holds whether edges are dense or sparse.
- R5: With bits 6..0 = 0, the ratio is 128 counted edges per tick.
- R6: A ratio written while a period is running takes effect only after that period completes. The running period keeps the old ratio.
- R7: When bit 7 changes, edges in the cycle where the change is first seen and in the following RESTART cycle are ignored. No tick follows from either cycle, and counting then restarts from zero with the current ratio.
- R8: With ratio 1, every counted edge produces a tick in the next cycle, so a continuous edge stream gives a continuous tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| int_edge | input | 1 | Single-cycle strobe per internal oscillator edge |
| ext_edge | input | 1 | Single-cycle strobe per external master clock edge |
| tick | output | 1 | One-cycle delay-timer enable pulse |
| rd_data | output | 8 | Control register readback |

## Verification
The bench targets the following corner cases:
- **Zero ratio field.** A design that treated it as stop or bypass would give no ticks or a tick on every edge, instead of one per 128 edges.
- **Mid-period ratio writes.** A design that reloaded at once would shorten or stretch the running period.
- **Divide-by-one with a continuous stream.** An off-by-one in the terminal count would drop every other tick.
- **Source switches while both strobes run.** A design without the two-cycle quiet window would leak a tick or carry a stale count into the new source.
- **Unselected strobe held active, and sparse edge patterns.** A wrong multiplexer would count the idle reference, and a design that counted cycles instead of edges would tick too early.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;
    typedef enum logic {
        ST_RESTART = 1'b0,
        ST_COUNT   = 1'b1
    } tdiv_state_e;
endpackage

// File: rtl/tdiv_ctrl_reg.sv
module tdiv_ctrl_reg #(
    parameter int          CTRL_W    = 8,
    parameter logic [CTRL_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctrl_q <= RESET_VAL;
        else if (wr_en) ctrl_q <= wr_data;
    end
endmodule

// File: rtl/tdiv_src_sel.sv
module tdiv_src_sel #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0]         edges,
    input  logic [$clog2(N_SRC)-1:0] sel,
    output logic                     ref_edge
);
    // Each strobe is qualified by its own select decode, then OR-reduced.
    logic [N_SRC-1:0] gated;
    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign gated[g] = edges[g] && (sel == g[$clog2(N_SRC)-1:0]);
    end
    assign ref_edge = |gated;
endmodule

// File: rtl/tdiv_counter.sv
module tdiv_counter
    import tdiv_pkg::*;
#(
    parameter int   FIELD_W   = 7,
    parameter logic RESET_SRC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_bit,
    input  logic [FIELD_W-1:0] field,
    input  logic               ref_edge,
    output logic               sel_q,
    output logic               tick
);
    localparam int RATIO_W = FIELD_W + 1;
    localparam int MAX_DIV = 1 << FIELD_W;

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [FIELD_W-1:0] f);
        return (f == '0) ? RATIO_W'(MAX_DIV) : {1'b0, f};
    endfunction

    tdiv_state_e        state_q, state_d;
    logic [RATIO_W-1:0] cnt_q, act_q;
    logic               switch_req, period_end, count_ok;

    assign switch_req = (src_bit != sel_q);
    assign period_end = (cnt_q == act_q - 1'b1);
    assign count_ok   = (state_q == ST_COUNT) && !switch_req && ref_edge;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESTART: state_d = ST_COUNT;
            ST_COUNT:   state_d = switch_req ? ST_RESTART : ST_COUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESTART;
        else        state_q <= state_d;
    end

    // counting datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= RATIO_W'(MAX_DIV);
            sel_q <= RESET_SRC;
        end else begin
            unique case (state_q)
                ST_RESTART: begin
                    cnt_q <= '0;
                    act_q <= ratio_of(field);
                    sel_q <= src_bit;
                end
                ST_COUNT: begin
                    if (count_ok) begin
                        if (period_end) begin
                            cnt_q <= '0;
                            act_q <= ratio_of(field);
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= count_ok && period_end;
    end
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int FIELD_W = 7,
    parameter logic [FIELD_W:0] RESET_CTRL = {1'b1, {FIELD_W{1'b0}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [FIELD_W:0] wr_data,
    input  logic             int_edge,
    input  logic             ext_edge,
    output logic             tick,
    output logic [FIELD_W:0] rd_data
);
    localparam int CTRL_W  = FIELD_W + 1;
    localparam int SRC_BIT = CTRL_W - 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic              sel_q;
    logic              ref_edge;

    tdiv_ctrl_reg #(
        .CTRL_W   (CTRL_W),
        .RESET_VAL(RESET_CTRL)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .ctrl_q (ctrl_q)
    );

    // source 0 = internal oscillator, source 1 = external master clock
    tdiv_src_sel #(.N_SRC(2)) u_sel (
        .edges   ({ext_edge, int_edge}),
        .sel     (sel_q),
        .ref_edge(ref_edge)
    );

    tdiv_counter #(
        .FIELD_W  (FIELD_W),
        .RESET_SRC(RESET_CTRL[SRC_BIT])
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_bit (ctrl_q[SRC_BIT]),
        .field   (ctrl_q[FIELD_W-1:0]),
        .ref_edge(ref_edge),
        .sel_q   (sel_q),
        .tick    (tick)
    );

    assign rd_data = ctrl_q;
endmodule

// File: rtl/tick_divider_chk.sv
module tick_divider_chk #(
    parameter int FIELD_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [FIELD_W:0] wr_data,
    input logic             int_edge,
    input logic             ext_edge,
    input logic             tick,
    input logic [FIELD_W:0] rd_data
);
    // R1: reset value of the control register
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> rd_data == {1'b1, {FIELD_W{1'b0}}});

    // R2: a write lands on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    // R2: no write, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    // R3: a tick always follows some reference edge
    a_r3_tick_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(int_edge || ext_edge));

    // R7: two quiet cycles after a source flip
    a_r7_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[FIELD_W] != rd_data[FIELD_W])) |=> ##1 !tick ##1 !tick);
endmodule

bind tick_divider tick_divider_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .int_edge(int_edge),
    .ext_edge(ext_edge),
    .tick    (tick),
    .rd_data (rd_data)
);

// File: tb/test_tick_divider.sv
module test_tick_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       int_edge = 1'b0;
    logic       ext_edge = 1'b0;
    logic       tick;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    tick_divider i_tick_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .int_edge(int_edge),
        .ext_edge(ext_edge),
        .tick    (tick),
        .rd_data (rd_data)
    );

    int    total = 0;
    int    bad = 0;
    int    tick_cnt = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // behavioural reference
    logic [7:0] m_reg = 8'h80;
    bit         m_sel = 1'b1;
    bit         m_restart = 1'b1;
    int         m_cnt = 0;
    int         m_act = 128;
    bit         m_tick = 1'b0;

    function automatic int div_of(input logic [7:0] r);
        return (r[6:0] == 7'd0) ? 128 : int'(r[6:0]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = 8'h80; m_sel = 1'b1; m_restart = 1'b1;
            m_cnt = 0; m_act = 128; m_tick = 1'b0;
        end else begin
            bit nt;
            bit e;
            nt = 1'b0;
            if (m_restart) begin
                m_cnt = 0; m_act = div_of(m_reg); m_sel = m_reg[7]; m_restart = 1'b0;
            end else if (m_reg[7] != m_sel) begin
                m_restart = 1'b1;
            end else begin
                e = m_sel ? ext_edge : int_edge;
                if (e) begin
                    if (m_cnt == m_act - 1) begin
                        nt = 1'b1; m_cnt = 0; m_act = div_of(m_reg);
                    end else begin
                        m_cnt++;
                    end
                end
            end
            if (wr_en) m_reg = wr_data;
            m_tick = nt;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
        end
    endtask

    // compare against the model on every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tick == m_tick, tag, "tick vs model", int'(tick), int'(m_tick));
            check(rd_data == m_reg, tag, "readback vs model", int'(rd_data), int'(m_reg));
            if (tick) tick_cnt++;
        end
    end

    task automatic drive(input int n, input bit ie, input bit ee);
        repeat (n) begin
            int_edge = ie; ext_edge = ee;
            @(negedge clk);
        end
        int_edge = 1'b0; ext_edge = 1'b0;
    endtask

    task automatic write(input logic [7:0] d, input bit ie, input bit ee);
        wr_en = 1'b1; wr_data = d; int_edge = ie; ext_edge = ee;
        @(negedge clk);
        wr_en = 1'b0; int_edge = 1'b0; ext_edge = 1'b0;
        check(rd_data == d, "R2", "readback after write", int'(rd_data), int'(d));
    endtask

    task automatic expect_ticks(input string req, input int exp);
        drive(2, 1'b0, 1'b0);
        check(tick_cnt == exp, req, "tick count", tick_cnt, exp);
    endtask

    initial begin : watchdog
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog timeout got=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: values held in reset
        check(rd_data == 8'h80, "R1", "readback in reset", int'(rd_data), 8'h80);
        check(tick == 1'b0, "R1", "tick in reset", int'(tick), 0);
        rst_n = 1'b1;

        // R5: default ext / 128; first cycle is RESTART, then 256 edges
        tag = "R5"; tick_cnt = 0;
        drive(257, 1'b0, 1'b1);
        expect_ticks("R5", 2);

        // R7: switch to internal, divide by 5
        tag = "R7";
        write(8'h05, 1'b0, 1'b0);
        drive(3, 1'b0, 1'b0);

        // R3: external strobe ignored while internal selected
        tag = "R3"; tick_cnt = 0;
        drive(30, 1'b0, 1'b1);
        expect_ticks("R3", 0);

        // R4: dense internal edges, divide by 5
        tag = "R4"; tick_cnt = 0;
        drive(50, 1'b1, 1'b0);
        expect_ticks("R4", 10);

        // R6: ratio 7 written; one more period of 5 first, sparse edges
        tag = "R6"; tick_cnt = 0;
        write(8'h07, 1'b0, 1'b0);
        for (int i = 0; i < 19; i++) begin
            drive(1, 1'b1, 1'b0);
            drive(2, 1'b0, 1'b0);
        end
        expect_ticks("R6", 3);

        // R8: divide by one after finishing the period of 7
        tag = "R8"; tick_cnt = 0;
        write(8'h01, 1'b0, 1'b0);
        drive(17, 1'b1, 1'b0);
        expect_ticks("R8", 11);

        // R5: zero field on internal; one period of 1 then two of 128
        tag = "R5"; tick_cnt = 0;
        write(8'h00, 1'b0, 1'b0);
        drive(257, 1'b1, 1'b0);
        expect_ticks("R5", 3);

        // R7: switch to external /2 with both strobes running throughout
        tag = "R7"; tick_cnt = 0;
        write(8'h82, 1'b1, 1'b1);
        drive(20, 1'b1, 1'b1);
        expect_ticks("R7", 9);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule